// File: doc/BRIEF.md
# Accumulator-Format Multi-Bit Shifter

This block shifts a 16-bit data word by 0 to 15 places and lays the outcome out as a 36-bit accumulator word. The word has three fields: a 4-bit extension (bits 35..32), a 16-bit high portion (bits 31..16) and a 16-bit low portion (bits 15..0). The shifted operand always lands in the high portion. The extension is rewritten after every shift. It takes the result's sign for arithmetic operations and zeros for logical ones. The low portion is cleared, except in the two right-shift-for-accumulate operations, where the bits that fall off the bottom of the operand are kept in the top of the low portion.

The shifting itself is combinational. Operands enter and results leave over valid/ready streams, with one register slice between them. A request is taken on a clock edge where `in_valid` and `in_ready` are both high. Its result appears with `out_valid` one cycle later. While `out_valid` is high and `out_ready` is low, the result is held unchanged and `in_ready` is low. `in_ready` is high whenever the slice is empty or its result is being taken in the same cycle. This allows one transfer per cycle under full flow.

Top module: `acc_barrel_shifter`

## Requirements
- R1: Operation code 0 (arithmetic right) places the operand shifted right by `in_count` in bits 31..16, with vacated upper positions copied from operand bit 15.
- R2: Operation code 1 (logical right) places the operand shifted right by `in_count` in bits 31..16, with zeros in vacated upper positions.
- R3: For arithmetic codes 0, 2 and 4, all four bits 35..32 equal result bit 31. For logical codes 1, 3 and 5, bits 35..32 are zero.
- R4: For codes 0, 1, 2 and 3, bits 15..0 of the result are zero.
- R5: For codes 4 (arithmetic right, keep) and 5 (logical right, keep), bits 31..16 are as for codes 0 and 1 respectively. The low `in_count` bits of the operand appear in the top `in_count` bits of bits 15..0, in their original order, and the remaining low bits are zero.
- R6: Codes 2 (arithmetic left) and 3 (logical left) place the operand shifted left by `in_count` in bits 31..16, with zeros entering from below. Bits shifted out of the top are discarded and do not affect bits 35..32.
- R7: A count of 0 places the operand unchanged in bits 31..16, with the extension rule of R3 and a zero low portion.
- R8: Codes 6 and 7 produce an all-zero result.
- R9: While `out_valid` is high and `out_ready` is low, `out_result` and `out_valid` hold and `in_ready` is low. When the output is taken with no new input, `out_valid` falls on the next edge.
- R10: While `rst_n` is low, `out_valid` is 0, `out_result` is 0 and `in_ready` is 1.
- R11: A request accepted on one edge presents its result with `out_valid` high after the next edge. Full flow sustains one request per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Slice can take a request |
| in_operand | input | 16 | Data word to shift |
| in_count | input | 4 | Shift distance, 0..15 |
| in_op | input | 3 | Operation code (see R1..R8) |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 36 | Extension, high and low portions |

## Verification
The vectors target the sign boundary, where an arithmetic shift of 0x8000 by 15 must give all ones and 0x7FFF must give zero. A design that fills from the wrong bit fails both. Left shifts that push a one out of the top check that the extension follows the surviving bit 15 and not the lost bit; a design that leaks the carried bit into the extension gives 0xF instead of 0. The keep variants are run at counts 1, 8, 15 and 0 to catch bits placed at the bottom of the low portion, a reversed order, or a nonzero low portion at count 0. Stalling the consumer while a second request waits checks that the held result is not overwritten.

// File: rtl/acc_shift_pkg.sv
package acc_shift_pkg;

  localparam int DATA_W = 16;
  localparam int CNT_W  = 4;
  localparam int EXT_W  = 4;
  localparam int OP_W   = 3;
  localparam int ACC_W  = EXT_W + 2 * DATA_W;

  typedef enum logic [OP_W-1:0] {
    OP_ASR     = 3'd0,
    OP_LSR     = 3'd1,
    OP_ASL     = 3'd2,
    OP_LSL     = 3'd3,
    OP_ASR_KEEP = 3'd4,
    OP_LSR_KEEP = 3'd5
  } shift_op_e;

  function automatic logic op_known(input logic [OP_W-1:0] op);
    return (op <= OP_LSR_KEEP);
  endfunction

  function automatic logic op_arith(input logic [OP_W-1:0] op);
    return (op == OP_ASR) || (op == OP_ASL) || (op == OP_ASR_KEEP);
  endfunction

  function automatic logic op_right(input logic [OP_W-1:0] op);
    return (op == OP_ASR) || (op == OP_LSR) ||
           (op == OP_ASR_KEEP) || (op == OP_LSR_KEEP);
  endfunction

  function automatic logic op_keep(input logic [OP_W-1:0] op);
    return (op == OP_ASR_KEEP) || (op == OP_LSR_KEEP);
  endfunction

endpackage

// File: rtl/acc_shift_stages.sv
module acc_shift_stages #(
  parameter int W    = 32,
  parameter int CW   = 4,
  parameter bit LEFT = 1'b0
) (
  input  logic [W-1:0]  din,
  input  logic [CW-1:0] amt,
  input  logic          fill,
  output logic [W-1:0]  dout
);

  logic [W-1:0] stage [CW+1];

  assign stage[0] = din;

  for (genvar i = 0; i < CW; i++) begin : g_stage
    localparam int STEP = 1 << i;
    if (LEFT) begin : g_left
      assign stage[i+1] = amt[i] ? {stage[i][W-STEP-1:0], {STEP{fill}}} : stage[i];
    end else begin : g_right
      assign stage[i+1] = amt[i] ? {{STEP{fill}}, stage[i][W-1:STEP]} : stage[i];
    end
  end

  assign dout = stage[CW];

endmodule

// File: rtl/acc_shift_core.sv
module acc_shift_core
  import acc_shift_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int CW = CNT_W,
  parameter int EW = EXT_W,
  parameter int OW = OP_W,
  localparam int AW = EW + 2 * DW
) (
  input  logic [DW-1:0] operand,
  input  logic [CW-1:0] count,
  input  logic [OW-1:0] op,
  output logic [AW-1:0] result
);

  logic [2*DW-1:0] right_word;
  logic [DW-1:0]   left_word;
  logic [DW-1:0]   high_part;
  logic [DW-1:0]   low_part;
  logic [EW-1:0]   ext_part;
  logic            is_arith;
  logic            is_right;
  logic            is_keep;
  logic            is_known;

  assign is_arith = op_arith(op);
  assign is_right = op_right(op);
  assign is_keep  = op_keep(op);
  assign is_known = op_known(op);

  // One wide right shift yields high and low portions together.
  acc_shift_stages #(.W(2*DW), .CW(CW), .LEFT(1'b0)) u_right (
    .din  ({operand, {DW{1'b0}}}),
    .amt  (count),
    .fill (is_arith & operand[DW-1]),
    .dout (right_word)
  );

  acc_shift_stages #(.W(DW), .CW(CW), .LEFT(1'b1)) u_left (
    .din  (operand),
    .amt  (count),
    .fill (1'b0),
    .dout (left_word)
  );

  always_comb begin
    high_part = is_right ? right_word[2*DW-1:DW] : left_word;
    low_part  = (is_right && is_keep) ? right_word[DW-1:0] : '0;
    ext_part  = is_arith ? {EW{high_part[DW-1]}} : '0;
    result    = is_known ? {ext_part, high_part, low_part} : '0;
  end

  always_comb begin
    if (!$isunknown(op) && !$isunknown(operand) && !$isunknown(count)) begin
      if (is_known && !is_arith)
        p_logic_ext_r3: assert (result[AW-1:2*DW] == '0);
      if (is_known && !is_keep)
        p_lsp_clear_r4: assert (result[DW-1:0] == '0);
    end
  end

endmodule

// File: rtl/acc_shift_slice.sv
module acc_shift_slice #(
  parameter int W = 36
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  p_drain_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !in_valid |=> !out_valid);

  p_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid && (out_data == $past(in_data)));

endmodule

// File: rtl/acc_barrel_shifter.sv
module acc_barrel_shifter
  import acc_shift_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_operand,
  input  logic [CNT_W-1:0]  in_count,
  input  logic [OP_W-1:0]   in_op,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ACC_W-1:0]  out_result
);

  logic [ACC_W-1:0] shaped;

  acc_shift_core #(.DW(DATA_W), .CW(CNT_W), .EW(EXT_W), .OW(OP_W)) u_core (
    .operand (in_operand),
    .count   (in_count),
    .op      (in_op),
    .result  (shaped)
  );

  acc_shift_slice #(.W(ACC_W)) u_slice (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (shaped),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_result)
  );

  p_ext_sign_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_result[ACC_W-1:2*DATA_W] == '0) ||
                  ((out_result[ACC_W-1:2*DATA_W] == '1) && out_result[2*DATA_W-1]));

endmodule

// File: tb/acc_barrel_shifter_test.sv
module acc_barrel_shifter_test;

  localparam int VW = 3 + 16 + 4 + 36;
  localparam int NV = 18;

  // {op, operand, count, expected}
  localparam logic [VW-1:0] VEC [NV] = '{
    {3'd0, 16'hA000, 4'd4,  36'hF_FA00_0000},
    {3'd1, 16'hA000, 4'd4,  36'h0_0A00_0000},
    {3'd2, 16'h0AAA, 4'd4,  36'hF_AAA0_0000},
    {3'd3, 16'h0AAA, 4'd4,  36'h0_AAA0_0000},
    {3'd4, 16'h8123, 4'd8,  36'hF_FF81_2300},
    {3'd5, 16'h8123, 4'd8,  36'h0_0081_2300},
    {3'd0, 16'h7FFF, 4'd15, 36'h0_0000_0000},
    {3'd0, 16'h8000, 4'd15, 36'hF_FFFF_0000},
    {3'd5, 16'hFFFF, 4'd15, 36'h0_0001_FFFE},
    {3'd2, 16'h4001, 4'd1,  36'hF_8002_0000},
    {3'd2, 16'h8001, 4'd1,  36'h0_0002_0000},
    {3'd4, 16'h9234, 4'd0,  36'hF_9234_0000},
    {3'd3, 16'h1234, 4'd0,  36'h0_1234_0000},
    {3'd6, 16'h1234, 4'd3,  36'h0_0000_0000},
    {3'd7, 16'hFFFF, 4'd1,  36'h0_0000_0000},
    {3'd3, 16'hFFFF, 4'd15, 36'h0_8000_0000},
    {3'd4, 16'h1235, 4'd1,  36'h0_091A_8000},
    {3'd1, 16'h8000, 4'd0,  36'h0_8000_0000}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_operand = '0;
  logic [3:0]  in_count = '0;
  logic [2:0]  in_op = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [35:0] out_result;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  acc_barrel_shifter uut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_operand(in_operand), .in_count(in_count), .in_op(in_op),
    .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result)
  );

  task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string req_of(input logic [2:0] op, input logic [3:0] cnt);
    if (op > 3'd5) return "R8";
    if (cnt == 4'd0) return "R7";
    case (op)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2, 3'd3: return "R6";
      default: return "R5";
    endcase
  endfunction

  task automatic drive(input logic [2:0] op, input logic [15:0] d, input logic [3:0] c);
    in_op = op; in_operand = d; in_count = c; in_valid = 1'b1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset state
    check("R10 out_valid", {35'd0, out_valid}, 36'd0);
    check("R10 out_result", out_result, 36'd0);
    check("R10 in_ready", {35'd0, in_ready}, 36'd1);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [2:0]  vop;
      logic [15:0] vd;
      logic [3:0]  vc;
      logic [35:0] ve;
      {vop, vd, vc, ve} = VEC[i];
      @(negedge clk);
      drive(vop, vd, vc);
      @(negedge clk);
      in_valid = 1'b0;
      check("R11 out_valid after accept", {35'd0, out_valid}, 36'd1);
      check(req_of(vop, vc), out_result, ve);
      // R3 / R4 field rules on every vector
      if (vop <= 3'd5)
        check("R3 extension fill", {32'd0, out_result[35:32]},
              {32'd0, (vop == 3'd0 || vop == 3'd2 || vop == 3'd4) ? {4{out_result[31]}} : 4'h0});
      if (vop <= 3'd3)
        check("R4 low portion clear", {20'd0, out_result[15:0]}, 36'd0);
    end

    // R11: back-to-back flow, one per cycle
    @(negedge clk);
    drive(3'd1, 16'hF000, 4'd4);
    @(negedge clk);
    check("R11 first of pair", out_result, 36'h0_0F00_0000);
    drive(3'd0, 16'hF000, 4'd4);
    @(negedge clk);
    in_valid = 1'b0;
    check("R11 second of pair", out_result, 36'hF_FF00_0000);
    check("R11 valid second", {35'd0, out_valid}, 36'd1);

    // R9: stall holds result and blocks input
    @(negedge clk);
    out_ready = 1'b0;
    drive(3'd3, 16'h0001, 4'd15);
    @(negedge clk);
    check("R9 held first result", out_result, 36'h0_8000_0000);
    drive(3'd2, 16'h0003, 4'd2);
    check("R9 in_ready low", {35'd0, in_ready}, 36'd0);
    @(negedge clk);
    check("R9 result stable", out_result, 36'h0_8000_0000);
    check("R9 valid held", {35'd0, out_valid}, 36'd1);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R9 waiting request delivered", out_result, 36'h0_000C_0000);
    @(negedge clk);
    check("R9 drain", {35'd0, out_valid}, 36'd0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule